// File: doc/BRIEF.md
# Inbound Mailbox Interrupt Status Controller

This block sits in a bridge between a host link and a local processor bus. It gathers the conditions that need the local processor's attention and drives a single level interrupt towards it. The host side writes a bank of inbound mailbox data registers. Each such write also marks a pending bit in a sticky status register. The link transaction logic raises two more pending bits with one-cycle failure pulses: one when a host-link write fails and one when a host-link read fails.

The local processor reaches the block through a simple synchronous register port. A read returns its data one cycle after the request. The processor reads the mailbox contents, which it cannot write. It acknowledges pending bits by writing ones to the status register. The two failure bits can also be acknowledged through a second status view, called the mirror register. An enable register chooses which pending bits may drive the interrupt, and it keeps only the bit positions that exist in the status register.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, every status, enable and mailbox register reads zero and `irq_o` is low.
- R2: A host write with `hwr_en` high and `hwr_idx` = i stores `hwr_data` in mailbox i. Mailbox i reads back at byte offset `MBOX_BASE + 4*i` (default base 0x3B20). A local write to a mailbox address leaves the mailbox unchanged.
- R3: A host write to mailbox i sets status bit 16+i on the same clock edge that stores the data.
- R4: A one-cycle pulse on `wr_fail_i` sets status bit 0. A one-cycle pulse on `rd_fail_i` sets status bit 1.
- R5: A local write to the status register (offset 0x3060) clears each implemented bit whose write-data bit is 1. Write-data bits of 0 leave the status unchanged.
- R6: Status bits 15:2 and 31:24 always read as zero, even after a local write of all ones.
- R7: The mirror register at offset 0x3050 reads status bits 1:0 in bits 1:0 and zero elsewhere. Writing 1 to bit 0 or bit 1 of the mirror register clears that failure bit. Its other write-data bits do not affect the mailbox status bits.
- R8: The enable register at offset 0x3070 is read/write. It stores only bits 0, 1 and 23:16. All other enable bits read as zero after any write.
- R9: `irq_o` goes high one cycle after some status bit and its enable bit are both 1. It goes low one cycle after the last such pair is broken, whether the status bit is cleared or the enable bit is cleared.
- R10: If a set event and a write-one-to-clear reach the same status bit on the same edge, the bit ends up set.
- R11: Read data appears on `lcl_rdata` in the cycle after `lcl_rd`. An address that maps to no register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr_en | input | 1 | Host-side mailbox write strobe |
| hwr_idx | input | 3 | Index of the mailbox being written |
| hwr_data | input | 32 | Data for the host-side mailbox write |
| wr_fail_i | input | 1 | Pulse: a host-link write failed |
| rd_fail_i | input | 1 | Pulse: a host-link read failed |
| lcl_wr | input | 1 | Local register write strobe |
| lcl_rd | input | 1 | Local register read strobe |
| lcl_addr | input | 14 | Local byte address |
| lcl_wdata | input | 32 | Local write data |
| lcl_rdata | output | 32 | Local read data, registered |
| irq_o | output | 1 | Level interrupt to the local processor |

## Verification
The bench builds the block with its defaults: eight mailboxes, a 32-bit data path, the mailbox pending bits starting at bit 16, and a 14-bit address. With all eight mailboxes present, each mailbox pending bit can be raised and cleared, and the full 0x00FF0003 implemented mask can be checked against all-ones writes to the status and enable registers. With these defaults the boundary between implemented and reserved bits falls at both bit 15:16 and bit 23:24, so the bench can test both reserved fields. Because the interrupt output and the read data both come from registers, the bench can check the exact cycle of interrupt assert and deassert, and of a set and a clear that collide on the same edge.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MIRR,
      SEL_EN,
      SEL_MBOX
   } reg_sel_e;

   // mask of the status positions that exist: the two failure bits plus the mailbox field
   function automatic logic [63:0] impl_mask(input int unsigned n_mbox,
                                             input int unsigned mb_lsb);
      logic [63:0] m;
      m = 64'h3;
      for (int unsigned i = 0; i < n_mbox; i++) begin
         m[mb_lsb + i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_MBOX = 8,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_MBOX-1:0] hit_vec
);

   logic [NUM_MBOX-1:0][DATA_W-1:0] slot_q;

   generate
      for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
         assign hit_vec[g] = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[g] <= '0;
            end else if (hit_vec[g]) begin
               slot_q[g] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int unsigned i = 0; i < NUM_MBOX; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = slot_q[i];
         end
      end
   end

   // R2
   mbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec == '0) |=> $stable(slot_q));

endmodule

// File: rtl/mbox_status.sv
module mbox_status
   import mbox_irq_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_MBOX = 8,
   parameter int unsigned MBOX_LSB = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_fail,
   input  logic                rd_fail,
   input  logic [NUM_MBOX-1:0] mbox_hit,
   input  logic [DATA_W-1:0]   stat_w1c,
   input  logic [DATA_W-1:0]   mirr_w1c,
   input  logic                en_we,
   input  logic [DATA_W-1:0]   en_wdata,
   output logic [DATA_W-1:0]   stat_q,
   output logic [DATA_W-1:0]   en_q,
   output logic                irq
);

   localparam logic [63:0]       MASK64    = impl_mask(NUM_MBOX, MBOX_LSB);
   localparam logic [DATA_W-1:0] IMPL      = MASK64[DATA_W-1:0];
   localparam logic [DATA_W-1:0] FAIL_MASK = DATA_W'(3);

   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_all;
   logic [DATA_W-1:0] stat_d;
   logic              irq_q;

   always_comb begin
      set_vec    = '0;
      set_vec[0] = wr_fail;
      set_vec[1] = rd_fail;
      set_vec[MBOX_LSB +: NUM_MBOX] = mbox_hit;
   end

   assign clr_all = (stat_w1c | (mirr_w1c & FAIL_MASK)) & IMPL;
   // set wins over a clear on the same edge
   assign stat_d  = ((stat_q & ~clr_all) | set_vec) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         if (en_we) begin
            en_q <= en_wdata & IMPL;
         end
         irq_q  <= |(stat_q & en_q);
      end
   end

   assign irq = irq_q;

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

   // R5
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_all & ~set_vec) != '0) |=> ((stat_q & $past(clr_all & ~set_vec)) == '0));

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~IMPL) == '0) && ((en_q & ~IMPL) == '0));

   // R7
   mirror_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_w1c == '0) && (mirr_w1c != '0)) |=>
         (stat_q[MBOX_LSB +: NUM_MBOX] == $past(stat_q[MBOX_LSB +: NUM_MBOX]) | $past(mbox_hit)));

endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 14,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_MBOX  = 8,
   parameter int unsigned IDX_W     = 3,
   parameter logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(14'h3060),
   parameter logic [ADDR_W-1:0] MIRR_OFS  = ADDR_W'(14'h3050),
   parameter logic [ADDR_W-1:0] EN_OFS    = ADDR_W'(14'h3070),
   parameter logic [ADDR_W-1:0] MBOX_BASE = ADDR_W'(14'h3B20)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] en_q,
   input  logic [DATA_W-1:0] mbox_rdata,
   output logic [IDX_W-1:0]  mbox_idx,
   output logic [DATA_W-1:0] stat_w1c,
   output logic [DATA_W-1:0] mirr_w1c,
   output logic              en_we,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned SPAN = 4 * NUM_MBOX;

   reg_sel_e          sel;
   logic [ADDR_W-1:0] mb_off;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign mb_off   = addr - MBOX_BASE;
   assign mbox_idx = mb_off[IDX_W+1:2];

   always_comb begin
      sel = SEL_NONE;
      if (addr == STAT_OFS) begin
         sel = SEL_STAT;
      end else if (addr == MIRR_OFS) begin
         sel = SEL_MIRR;
      end else if (addr == EN_OFS) begin
         sel = SEL_EN;
      end else if ((addr >= MBOX_BASE) && (32'(mb_off) < SPAN) && (addr[1:0] == 2'b00)) begin
         sel = SEL_MBOX;
      end
   end

   assign stat_w1c = (wr && sel == SEL_STAT) ? wdata : '0;
   assign mirr_w1c = (wr && sel == SEL_MIRR) ? wdata : '0;
   assign en_we    = wr && (sel == SEL_EN);

   always_comb begin
      unique case (sel)
         SEL_STAT: rd_mux = stat_q;
         SEL_MIRR: rd_mux = {{(DATA_W-2){1'b0}}, stat_q[1:0]};
         SEL_EN:   rd_mux = en_q;
         SEL_MBOX: rd_mux = mbox_rdata;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd) begin
         rdata_q <= rd_mux;
      end
   end

   assign rdata = rdata_q;

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata_q));

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_MBOX = 8,
   parameter int unsigned MBOX_LSB = 16,
   parameter logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(14'h3060),
   parameter logic [ADDR_W-1:0] MIRR_OFS  = ADDR_W'(14'h3050),
   parameter logic [ADDR_W-1:0] EN_OFS    = ADDR_W'(14'h3070),
   parameter logic [ADDR_W-1:0] MBOX_BASE = ADDR_W'(14'h3B20),
   localparam int unsigned IDX_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hwr_en,
   input  logic [IDX_W-1:0]  hwr_idx,
   input  logic [DATA_W-1:0] hwr_data,
   input  logic              wr_fail_i,
   input  logic              rd_fail_i,
   input  logic              lcl_wr,
   input  logic              lcl_rd,
   input  logic [ADDR_W-1:0] lcl_addr,
   input  logic [DATA_W-1:0] lcl_wdata,
   output logic [DATA_W-1:0] lcl_rdata,
   output logic              irq_o
);

   generate
      if (NUM_MBOX < 1 || NUM_MBOX > 8) begin : g_bad_num
         $error("NUM_MBOX must lie in 1..8");
      end
      if (MBOX_LSB < 2 || MBOX_LSB + NUM_MBOX > DATA_W) begin : g_bad_lsb
         $error("mailbox field must sit above the failure bits and inside DATA_W");
      end
      if (DATA_W > 64 || DATA_W < 8) begin : g_bad_w
         $error("DATA_W must lie in 8..64");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_a
         $error("ADDR_W too narrow for the mailbox window");
      end
   endgenerate

   logic [NUM_MBOX-1:0] hit_vec;
   logic [IDX_W-1:0]    rd_idx;
   logic [DATA_W-1:0]   mbox_rdata;
   logic [DATA_W-1:0]   stat_w1c;
   logic [DATA_W-1:0]   mirr_w1c;
   logic                en_we;
   logic [DATA_W-1:0]   stat_q;
   logic [DATA_W-1:0]   en_q;

   mbox_bank #(
      .DATA_W  (DATA_W),
      .NUM_MBOX(NUM_MBOX),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (hwr_en),
      .wr_idx (hwr_idx),
      .wr_data(hwr_data),
      .rd_idx (rd_idx),
      .rd_data(mbox_rdata),
      .hit_vec(hit_vec)
   );

   mbox_status #(
      .DATA_W  (DATA_W),
      .NUM_MBOX(NUM_MBOX),
      .MBOX_LSB(MBOX_LSB)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fail (wr_fail_i),
      .rd_fail (rd_fail_i),
      .mbox_hit(hit_vec),
      .stat_w1c(stat_w1c),
      .mirr_w1c(mirr_w1c),
      .en_we   (en_we),
      .en_wdata(lcl_wdata),
      .stat_q  (stat_q),
      .en_q    (en_q),
      .irq     (irq_o)
   );

   mbox_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_MBOX (NUM_MBOX),
      .IDX_W    (IDX_W),
      .STAT_OFS (STAT_OFS),
      .MIRR_OFS (MIRR_OFS),
      .EN_OFS   (EN_OFS),
      .MBOX_BASE(MBOX_BASE)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (lcl_wr),
      .rd        (lcl_rd),
      .addr      (lcl_addr),
      .wdata     (lcl_wdata),
      .stat_q    (stat_q),
      .en_q      (en_q),
      .mbox_rdata(mbox_rdata),
      .mbox_idx  (rd_idx),
      .stat_w1c  (stat_w1c),
      .mirr_w1c  (mirr_w1c),
      .en_we     (en_we),
      .rdata     (lcl_rdata)
   );

   // R3
   host_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |=> ((stat_q[MBOX_LSB +: NUM_MBOX] & $past(hit_vec)) == $past(hit_vec)));

   // R4
   fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fail_i || rd_fail_i) |=> ((stat_q[1:0] & $past({rd_fail_i, wr_fail_i})) == $past({rd_fail_i, wr_fail_i})));

endmodule

// File: tb/mbox_irq_ctrl_test.sv
module mbox_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [13:0] A_STAT = 14'h3060;
   localparam logic [13:0] A_MIRR = 14'h3050;
   localparam logic [13:0] A_EN   = 14'h3070;
   localparam logic [13:0] A_MB   = 14'h3B20;
   localparam logic [31:0] IMPL   = 32'h00FF_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hwr_en = 1'b0;
   logic [2:0]  hwr_idx = '0;
   logic [31:0] hwr_data = '0;
   logic        wr_fail_i = 1'b0;
   logic        rd_fail_i = 1'b0;
   logic        lcl_wr = 1'b0;
   logic        lcl_rd = 1'b0;
   logic [13:0] lcl_addr = '0;
   logic [31:0] lcl_wdata = '0;
   logic [31:0] lcl_rdata;
   logic        irq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   mbox_irq_ctrl uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .hwr_en   (hwr_en),
      .hwr_idx  (hwr_idx),
      .hwr_data (hwr_data),
      .wr_fail_i(wr_fail_i),
      .rd_fail_i(rd_fail_i),
      .lcl_wr   (lcl_wr),
      .lcl_rd   (lcl_rd),
      .lcl_addr (lcl_addr),
      .lcl_wdata(lcl_wdata),
      .lcl_rdata(lcl_rdata),
      .irq_o    (irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // one edge with the given local write
   task automatic lwrite(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      lcl_wr = 1'b1; lcl_addr = a; lcl_wdata = d;
      @(negedge clk);
      lcl_wr = 1'b0;
   endtask

   task automatic lread(input logic [13:0] a, output logic [31:0] d);
      @(negedge clk);
      lcl_rd = 1'b1; lcl_addr = a;
      @(negedge clk);
      lcl_rd = 1'b0;
      d = lcl_rdata;
   endtask

   task automatic hwrite(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      hwr_en = 1'b1; hwr_idx = i; hwr_data = d;
      @(negedge clk);
      hwr_en = 1'b0;
   endtask

   task automatic clear_all();
      lwrite(A_EN, 32'h0);
      lwrite(A_STAT, 32'hFFFF_FFFF);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
      lread(A_STAT, d); chk("R1 status after reset", d, 32'h0);
      lread(A_EN, d);   chk("R1 enable after reset", d, 32'h0);
      for (int i = 0; i < 8; i++) begin
         lread(A_MB + 14'(4*i), d); chk("R1 mailbox after reset", d, 32'h0);
      end
   endtask

   task automatic t_mailbox();
      logic [31:0] d;
      hwrite(3'd3, 32'hA5A5_0003);
      lread(A_MB + 14'd12, d); chk("R2 mailbox 3 data", d, 32'hA5A5_0003);
      lread(A_STAT, d);        chk("R3 status bit 19", d, 32'h0008_0000);
      lwrite(A_MB + 14'd12, 32'h1234_5678);
      lread(A_MB + 14'd12, d); chk("R2 local write ignored", d, 32'hA5A5_0003);
      hwrite(3'd7, 32'h7777_0007);
      lread(A_MB + 14'd28, d); chk("R2 mailbox 7 data", d, 32'h7777_0007);
      lread(A_STAT, d);        chk("R3 status bits 19,23", d, 32'h0088_0000);
      clear_all();
   endtask

   task automatic t_fail();
      logic [31:0] d;
      @(negedge clk); wr_fail_i = 1'b1;
      @(negedge clk); wr_fail_i = 1'b0;
      lread(A_STAT, d); chk("R4 write failure bit 0", d, 32'h1);
      @(negedge clk); rd_fail_i = 1'b1;
      @(negedge clk); rd_fail_i = 1'b0;
      lread(A_STAT, d); chk("R4 read failure bit 1", d, 32'h3);
      clear_all();
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      hwrite(3'd1, 32'h1);
      hwrite(3'd4, 32'h4);
      lwrite(A_STAT, 32'h0);
      lread(A_STAT, d); chk("R5 zero write no effect", d, 32'h0012_0000);
      lwrite(A_STAT, 32'h0010_0000);
      lread(A_STAT, d); chk("R5 clear bit 20 only", d, 32'h0002_0000);
      clear_all();
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) hwrite(3'(i), 32'(i));
      @(negedge clk); wr_fail_i = 1'b1; rd_fail_i = 1'b1;
      @(negedge clk); wr_fail_i = 1'b0; rd_fail_i = 1'b0;
      lread(A_STAT, d); chk("R6 reserved status zero", d, IMPL);
      lread(A_MIRR, d); chk("R7 mirror read", d, 32'h3);
      lwrite(A_MIRR, 32'hFFFF_FFFF);
      lread(A_STAT, d); chk("R7 mirror clears failures only", d, 32'h00FF_0000);
      lwrite(A_STAT, 32'hFFFF_FFFF);
      lread(A_STAT, d); chk("R6 status after all-ones clear", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      lwrite(A_EN, 32'hFFFF_FFFF);
      lread(A_EN, d); chk("R8 enable keeps implemented bits", d, IMPL);
      lwrite(A_EN, 32'h0000_FFF2);
      lread(A_EN, d); chk("R8 enable reserved zero", d, 32'h2);
      clear_all();
   endtask

   task automatic t_irq();
      lwrite(A_EN, 32'h0010_0000);
      @(negedge clk);
      hwr_en = 1'b1; hwr_idx = 3'd4; hwr_data = 32'h44;
      @(negedge clk);
      hwr_en = 1'b0;
      chk("R9 irq not yet high", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R9 irq high one cycle later", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      lcl_wr = 1'b1; lcl_addr = A_STAT; lcl_wdata = 32'h0010_0000;
      @(negedge clk);
      lcl_wr = 1'b0;
      chk("R9 irq held one cycle after clear", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R9 irq low after clear", {31'b0, irq_o}, 32'h0);
      hwrite(3'd4, 32'h45);
      @(negedge clk);
      chk("R9 irq high again", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      lcl_wr = 1'b1; lcl_addr = A_EN; lcl_wdata = 32'h0;
      @(negedge clk);
      lcl_wr = 1'b0;
      chk("R9 irq held one cycle after mask", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R9 irq low after mask", {31'b0, irq_o}, 32'h0);
      clear_all();
   endtask

   task automatic t_collide();
      logic [31:0] d;
      hwrite(3'd5, 32'h5);
      @(negedge clk);
      hwr_en = 1'b1; hwr_idx = 3'd5; hwr_data = 32'h55;
      lcl_wr = 1'b1; lcl_addr = A_STAT; lcl_wdata = 32'h0020_0000;
      @(negedge clk);
      hwr_en = 1'b0; lcl_wr = 1'b0;
      lread(A_STAT, d); chk("R10 set wins over clear", d, 32'h0020_0000);
      clear_all();
   endtask

   task automatic t_read();
      logic [31:0] d;
      hwrite(3'd2, 32'hCAFE_0002);
      @(negedge clk);
      lcl_rd = 1'b1; lcl_addr = A_MB + 14'd8;
      chk("R11 data not before edge", lcl_rdata, 32'h0);
      @(negedge clk);
      lcl_rd = 1'b0;
      chk("R11 data one cycle after read", lcl_rdata, 32'hCAFE_0002);
      lread(14'h0000, d); chk("R11 unmapped reads zero", d, 32'h0);
      lread(A_MB + 14'd9, d); chk("R11 misaligned reads zero", d, 32'h0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_mailbox();
      t_fail();
      t_w1c();
      t_reserved();
      t_enable();
      t_irq();
      t_collide();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

endmodule